// File: doc/BRIEF.md
# Management Register Unit with Built-in PHY Model

This block is a small memory-mapped management unit that holds the register file of a single PHY modelled inside the block. Software selects a target PHY and a register number through an address word. Writing the control-data word sends its low half to the selected PHY register. Writing bit 0 of the command word reads the selected register and parks the 16-bit answer in a result word, where software can read it back.

Only the PHY at address 1 answers. Any other address reads as all ones and ignores writes. The modelled PHY finishes a self-reset or an auto-negotiation request within the same write. An external link input is mirrored into two bits of the PHY status register. No serial management waveform is produced, and the block has no register beyond the 32-entry file.

The bus side is a 32-bit word-addressed write port and read port. Both are always ready. Read data returns one cycle after the request.

Top module: `mgmt_phy_top`

## Requirements
- R1: Word 0 is the address word. Bits [4:0] select the PHY register and bits [12:8] select the PHY address. A read of word 0 returns these two fields at the same positions, with every other bit 0.
- R2: Only PHY address 1 responds. A command read at any other PHY address puts 0xFFFF in the result word. A control-data write to any other PHY address changes no PHY register.
- R3: Writing word 2 with bit 0 set copies the selected 16-bit PHY register into the result word at word 3. The copy is read back zero-extended. Writing word 2 with bit 0 clear leaves the result unchanged.
- R4: Writing word 1 stores the full 32-bit value, which reads back unchanged, and writes its bits [15:0] into the selected PHY register.
- R5: After the block reset, the PHY registers hold these values: register 0 is 0x1140, register 1 is 0x7968 with bits 5 and 2 set by the link, register 2 is 0x0022, register 3 is 0x1550, register 4 is 0x01E1, register 5 is 0xCDE1, and all other registers are 0. Word 0 and the result word read 0.
- R6: A write to register 0 with bit 15 set reloads every register with its reset value and then stores the written value in register 0 with bit 15 cleared.
- R7: A write to register 0 with bit 12 set stores the value with bit 12 cleared and sets bit 5 of register 1 in the same cycle.
- R8: Whenever the link input changes, bits 5 and 2 of register 1 both take its new value. With the link up, register 1 reads 0x796C after reset, and with the link down it reads 0x7948.
- R9: The write and read ready outputs are always 1. The read valid output goes high exactly one cycle after a read request, carrying that word. Unmapped words and word 2 read as 0, and writes to word 3 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| linkUp | input | 1 | Link state mirrored into PHY status |
| wrValid | input | 1 | Write request |
| wrReady | output | 1 | Write accepted (always 1) |
| wrAddr | input | 4 | Write word address |
| wrData | input | 32 | Write data |
| rdValid | input | 1 | Read request |
| rdReady | output | 1 | Read accepted (always 1) |
| rdAddr | input | 4 | Read word address |
| rdData | output | 32 | Read data |
| rdDataValid | output | 1 | Read data valid, one cycle after request |

## Verification
The bench goes after the special cases of register 0.

- A self-reset with the auto-negotiation bit also set must leave register 0 at 0 and register 1 showing completion. A design that kept bit 15 or bit 12, or that reloaded after storing, would read back a nonzero control value or a wiped register 7.
- Auto-negotiation is requested while the link is down. A design that tied the completion bit to the link would never show it set.
- Foreign-address writes with the reset bit set are sent to check that nothing is reloaded.
- A command write with bit 0 clear must not refresh a stale result.
- The address word is written with junk in its unused bits, to catch a readback that keeps those bits or shifts a field.

// File: rtl/mgmt_phy_pkg.sv
package mgmt_phy_pkg;

  localparam int PHY_REGS   = 32;
  localparam int PHY_IDX_W  = $clog2(PHY_REGS);
  localparam int PHY_DW     = 16;
  localparam int PHY_AW     = 5;

  // bit positions inside the modelled PHY registers
  localparam int CTL_SELF_RESET = 15;
  localparam int CTL_AUTONEG    = 12;
  localparam int STS_AN_DONE    = 5;
  localparam int STS_LINK       = 2;

  // field positions in the address word
  localparam int AW_REG_LSB = 0;
  localparam int AW_PHY_LSB = 8;

  typedef struct packed {
    logic                 phyWrite;
    logic [PHY_IDX_W-1:0] regIdx;
    logic [PHY_DW-1:0]    wdata;
  } phyStrobe_t;

  function automatic logic [PHY_DW-1:0] phyResetValue(input int idx, input logic link);
    logic [PHY_DW-1:0] v;
    case (idx)
      0: v = 16'h1140;
      1: begin
        v = 16'h7968;
        v[STS_AN_DONE] = link;
        v[STS_LINK]    = link;
      end
      2: v = 16'h0022;
      3: v = 16'h1550;
      4: v = 16'h01E1;
      5: v = 16'hCDE1;
      default: v = '0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/mgmt_regif_ctrl.sv
module mgmt_regif_ctrl
  import mgmt_phy_pkg::*;
#(
  parameter int BUS_AW  = 4,
  parameter int OWN_PHY = 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrValid,
  input  logic [BUS_AW-1:0]    wrAddr,
  input  logic [31:0]          wrData,
  input  logic                 rdValid,
  input  logic [BUS_AW-1:0]    rdAddr,
  output logic [31:0]          rdData,
  output logic                 rdDataValid,
  input  logic [PHY_DW-1:0]    phyRdData,
  output phyStrobe_t           strb,
  output logic [PHY_AW-1:0]    phyAddrQ,
  output logic [PHY_IDX_W-1:0] regAddrQ,
  output logic [PHY_DW-1:0]    resultQ
);

  localparam logic [BUS_AW-1:0] W_ADDR   = BUS_AW'(0);
  localparam logic [BUS_AW-1:0] W_CDATA  = BUS_AW'(1);
  localparam logic [BUS_AW-1:0] W_CMD    = BUS_AW'(2);
  localparam logic [BUS_AW-1:0] W_RESULT = BUS_AW'(3);
  localparam logic [PHY_AW-1:0] OWN_ADDR = PHY_AW'(OWN_PHY);
  localparam logic [PHY_DW-1:0] NO_PHY   = '1;

  logic [31:0] cdataQ;
  logic [31:0] rdDataQ;
  logic        rdDataValidQ;
  logic        phyHit;
  logic [31:0] readMux;

  assign phyHit = (phyAddrQ == OWN_ADDR);

  always_comb begin
    strb          = '0;
    strb.phyWrite = wrValid && (wrAddr == W_CDATA) && phyHit;
    strb.regIdx   = regAddrQ;
    strb.wdata    = wrData[PHY_DW-1:0];
  end

  always_comb begin
    readMux = '0;
    case (rdAddr)
      W_ADDR: begin
        readMux[AW_REG_LSB +: PHY_IDX_W] = regAddrQ;
        readMux[AW_PHY_LSB +: PHY_AW]    = phyAddrQ;
      end
      W_CDATA:  readMux = cdataQ;
      W_RESULT: readMux[PHY_DW-1:0] = resultQ;
      default:  readMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regAddrQ     <= '0;
      phyAddrQ     <= '0;
      cdataQ       <= '0;
      resultQ      <= '0;
      rdDataQ      <= '0;
      rdDataValidQ <= 1'b0;
    end else begin
      rdDataValidQ <= rdValid;
      if (rdValid) rdDataQ <= readMux;
      if (wrValid) begin
        case (wrAddr)
          W_ADDR: begin
            regAddrQ <= wrData[AW_REG_LSB +: PHY_IDX_W];
            phyAddrQ <= wrData[AW_PHY_LSB +: PHY_AW];
          end
          W_CDATA: cdataQ <= wrData;
          W_CMD: begin
            if (wrData[0]) resultQ <= phyHit ? phyRdData : NO_PHY;
          end
          default: ;
        endcase
      end
    end
  end

  assign rdData      = rdDataQ;
  assign rdDataValid = rdDataValidQ;

endmodule

// File: rtl/mgmt_phy_file.sv
module mgmt_phy_file
  import mgmt_phy_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  phyStrobe_t        strb,
  output logic [PHY_DW-1:0] phyRdData,
  output logic [PHY_DW-1:0] ctrlWordMon,
  output logic [PHY_DW-1:0] statWordMon
);

  logic [PHY_REGS-1:0][PHY_DW-1:0] fileFlat;
  logic linkPrevQ;
  logic linkChange;
  logic bulkReset;
  logic anKick;

  assign linkChange = (linkUp != linkPrevQ);
  assign bulkReset  = strb.phyWrite && (strb.regIdx == '0) && strb.wdata[CTL_SELF_RESET];
  assign anKick     = strb.phyWrite && (strb.regIdx == '0) && strb.wdata[CTL_AUTONEG];

  always_ff @(posedge clk) begin
    linkPrevQ <= linkUp;
  end

  for (genvar gi = 0; gi < PHY_REGS; gi++) begin : g_entry
    logic [PHY_DW-1:0] entryQ;
    logic [PHY_DW-1:0] entryD;
    logic              hitW;

    assign hitW = strb.phyWrite && (strb.regIdx == PHY_IDX_W'(gi));

    always_comb begin
      entryD = bulkReset ? phyResetValue(gi, linkUp) : entryQ;
      if (hitW) entryD = strb.wdata;
      if (gi == 0 && hitW) begin
        entryD[CTL_SELF_RESET] = 1'b0;
        entryD[CTL_AUTONEG]    = 1'b0;
      end
      if (gi == 1) begin
        if (anKick) entryD[STS_AN_DONE] = 1'b1;
        if (linkChange) begin
          entryD[STS_AN_DONE] = linkUp;
          entryD[STS_LINK]    = linkUp;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) entryQ <= phyResetValue(gi, linkUp);
      else       entryQ <= entryD;
    end

    assign fileFlat[gi] = entryQ;
  end

  assign phyRdData   = fileFlat[strb.regIdx];
  assign ctrlWordMon = fileFlat[0];
  assign statWordMon = fileFlat[1];

endmodule

// File: rtl/mgmt_phy_top.sv
module mgmt_phy_top
  import mgmt_phy_pkg::*;
#(
  parameter int BUS_AW  = 4,
  parameter int OWN_PHY = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              linkUp,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [BUS_AW-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              rdValid,
  output logic              rdReady,
  input  logic [BUS_AW-1:0] rdAddr,
  output logic [31:0]       rdData,
  output logic              rdDataValid
);

  phyStrobe_t           strb;
  logic [PHY_DW-1:0]    phyRdData;
  logic [PHY_AW-1:0]    phyAddrMon;
  logic [PHY_IDX_W-1:0] regAddrMon;
  logic [PHY_DW-1:0]    resultMon;
  logic [PHY_DW-1:0]    ctrlWordMon;
  logic [PHY_DW-1:0]    statWordMon;

  assign wrReady = 1'b1;
  assign rdReady = 1'b1;

  mgmt_regif_ctrl #(.BUS_AW(BUS_AW), .OWN_PHY(OWN_PHY)) ctrl_i (
    .clk(clk), .rstN(rstN),
    .wrValid(wrValid), .wrAddr(wrAddr), .wrData(wrData),
    .rdValid(rdValid), .rdAddr(rdAddr), .rdData(rdData), .rdDataValid(rdDataValid),
    .phyRdData(phyRdData), .strb(strb),
    .phyAddrQ(phyAddrMon), .regAddrQ(regAddrMon), .resultQ(resultMon)
  );

  mgmt_phy_file file_i (
    .clk(clk), .rstN(rstN), .linkUp(linkUp), .strb(strb),
    .phyRdData(phyRdData), .ctrlWordMon(ctrlWordMon), .statWordMon(statWordMon)
  );

endmodule

// File: rtl/mgmt_phy_chk.sv
module mgmt_phy_chk
  import mgmt_phy_pkg::*;
#(
  parameter int BUS_AW  = 4,
  parameter int OWN_PHY = 1
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 linkUp,
  input logic                 wrValid,
  input logic [BUS_AW-1:0]    wrAddr,
  input logic                 wrBit0,
  input logic                 wrBit12,
  input logic                 rdValid,
  input logic                 rdDataValid,
  input logic [PHY_AW-1:0]    phyAddrQ,
  input logic [PHY_IDX_W-1:0] regAddrQ,
  input logic [PHY_DW-1:0]    resultQ,
  input logic [PHY_DW-1:0]    ctrlWord,
  input logic [PHY_DW-1:0]    statWord
);

  localparam logic [PHY_AW-1:0] OWN_ADDR = PHY_AW'(OWN_PHY);

  // R8
  link_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(linkUp) |=> statWord[STS_AN_DONE] && statWord[STS_LINK]);

  // R8
  link_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(linkUp) |=> !statWord[STS_AN_DONE] && !statWord[STS_LINK]);

  // R2
  foreign_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrAddr == BUS_AW'(2) && wrBit0 && phyAddrQ != OWN_ADDR
      |=> resultQ == 16'hFFFF);

  // R2
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrAddr == BUS_AW'(1) && phyAddrQ != OWN_ADDR && regAddrQ == '0
      |=> $stable(ctrlWord));

  // R6
  ctl_bits_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrAddr == BUS_AW'(1) && phyAddrQ == OWN_ADDR && regAddrQ == '0
      |=> !ctrlWord[CTL_SELF_RESET] && !ctrlWord[CTL_AUTONEG]);

  // R7
  an_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrValid && wrAddr == BUS_AW'(1) && phyAddrQ == OWN_ADDR && regAddrQ == '0
      && wrBit12 && linkUp == $past(linkUp)
      |=> statWord[STS_AN_DONE]);

  // R9
  read_resp_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> rdDataValid);

  // R9
  read_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |=> !rdDataValid);

endmodule

bind mgmt_phy_top mgmt_phy_chk #(.BUS_AW(BUS_AW), .OWN_PHY(OWN_PHY)) chk_i (
  .clk(clk), .rstN(rstN), .linkUp(linkUp),
  .wrValid(wrValid), .wrAddr(wrAddr), .wrBit0(wrData[0]), .wrBit12(wrData[12]),
  .rdValid(rdValid), .rdDataValid(rdDataValid),
  .phyAddrQ(phyAddrMon), .regAddrQ(regAddrMon), .resultQ(resultMon),
  .ctrlWord(ctrlWordMon), .statWord(statWordMon)
);

// File: tb/mgmt_phy_top_tb_top.sv
module mgmt_phy_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        linkUp = 1'b1;
  logic        wrValid = 1'b0;
  logic        wrReady;
  logic [3:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        rdValid = 1'b0;
  logic        rdReady;
  logic [3:0]  rdAddr = '0;
  logic [31:0] rdData;
  logic        rdDataValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  logic [31:0] expQ[$];
  string       tagQ[$];

  always #2 clk = ~clk;

  mgmt_phy_top dut_i (
    .clk(clk), .rstN(rstN), .linkUp(linkUp),
    .wrValid(wrValid), .wrReady(wrReady), .wrAddr(wrAddr), .wrData(wrData),
    .rdValid(rdValid), .rdReady(rdReady), .rdAddr(rdAddr),
    .rdData(rdData), .rdDataValid(rdDataValid)
  );

  task automatic note(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as responses appear
  always @(negedge clk) begin
    if (rstN && rdDataValid) begin
      if (expQ.size() == 0) begin
        note(1'b0, "R9 unexpected response", rdData, 32'h0);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        note(rdData === e, t, rdData, e);
      end
    end
  end

  task automatic wrReg(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wrValid = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic rdExp(input logic [3:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    rdValid = 1'b1; rdAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    rdValid = 1'b0;
  endtask

  task automatic phyRd(input int phy, input int idx, input logic [15:0] e, input string t);
    wrReg(4'd0, 32'((phy << 8) | idx));
    wrReg(4'd2, 32'h1);
    rdExp(4'd3, {16'h0, e}, t);
  endtask

  task automatic phyWr(input int phy, input int idx, input logic [31:0] d);
    wrReg(4'd0, 32'((phy << 8) | idx));
    wrReg(4'd1, d);
  endtask

  task automatic setLink(input logic v);
    @(negedge clk);
    linkUp = v;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    note(wrReady === 1'b1 && rdReady === 1'b1, "R9 ready high", {30'h0, wrReady, rdReady}, 32'h3);

    // R5 reset state
    rdExp(4'd0, 32'h0, "R5 address word reset");
    rdExp(4'd3, 32'h0, "R5 result word reset");
    phyRd(1, 0, 16'h1140, "R5 reg0 reset");
    phyRd(1, 1, 16'h796C, "R5 R8 reg1 reset link up");
    phyRd(1, 2, 16'h0022, "R5 reg2 reset");
    phyRd(1, 3, 16'h1550, "R5 reg3 reset");
    phyRd(1, 4, 16'h01E1, "R5 reg4 reset");
    phyRd(1, 5, 16'hCDE1, "R5 reg5 reset");
    phyRd(1, 6, 16'h0000, "R5 reg6 reset");

    // R1 field readback
    wrReg(4'd0, 32'hFFFF_E1F3);
    rdExp(4'd0, 32'h0000_0113, "R1 address fields");

    // R2 foreign address
    phyRd(2, 0, 16'hFFFF, "R2 foreign read");
    phyWr(3, 7, 32'h0000_ABCD);
    phyRd(1, 7, 16'h0000, "R2 foreign write ignored");
    phyWr(5, 0, 32'h0000_8000);
    phyRd(1, 0, 16'h1140, "R2 foreign reset ignored");

    // R4 control data
    phyWr(1, 7, 32'h1234_5A5A);
    rdExp(4'd1, 32'h1234_5A5A, "R4 control word readback");
    phyRd(1, 7, 16'h5A5A, "R4 low half forwarded");

    // R3 command bit 0 clear does nothing
    wrReg(4'd0, 32'h0000_0102);
    wrReg(4'd2, 32'h0000_0002);
    rdExp(4'd3, 32'h0000_5A5A, "R3 no trigger");
    wrReg(4'd2, 32'h0000_0001);
    rdExp(4'd3, 32'h0000_0022, "R3 trigger");

    // R8 link down
    setLink(1'b0);
    phyRd(1, 1, 16'h7948, "R8 link down");

    // R7 auto-negotiation with link down
    phyWr(1, 0, 32'h0000_1100);
    phyRd(1, 0, 16'h0100, "R7 an bit cleared");
    phyRd(1, 1, 16'h7968, "R7 an done set");

    setLink(1'b1);
    phyRd(1, 1, 16'h796C, "R8 link up");
    setLink(1'b0);
    phyRd(1, 1, 16'h7948, "R8 link down again");

    // R6 self reset
    phyWr(1, 7, 32'h0000_1111);
    phyWr(1, 4, 32'h0000_0000);
    phyWr(1, 0, 32'h0000_8040);
    phyRd(1, 0, 16'h0040, "R6 reset bit cleared");
    phyRd(1, 7, 16'h0000, "R6 reg7 reloaded");
    phyRd(1, 4, 16'h01E1, "R6 reg4 reloaded");
    phyRd(1, 1, 16'h7948, "R6 reg1 reloaded link down");
    phyWr(1, 0, 32'h0000_9000);
    phyRd(1, 0, 16'h0000, "R6 R7 combined reg0");
    phyRd(1, 1, 16'h7968, "R6 R7 combined reg1");

    // R9 unmapped and read-only
    rdExp(4'd5, 32'h0, "R9 unmapped reads zero");
    rdExp(4'd2, 32'h0, "R9 command reads zero");
    wrReg(4'd3, 32'hDEAD_BEEF);
    rdExp(4'd3, 32'h0000_7968, "R9 result write ignored");

    repeat (4) @(negedge clk);
    note(expQ.size() == 0, "R9 all responses returned", 32'(expQ.size()), 32'h0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule